// File: doc/BRIEF.md
# Host Reset Handshake Controller

This block sits in a development cartridge between the USB command side and the host computer. Before a new program is transferred and started, the host has to be reset. When a run request comes in, the controller does one of two things. If a reset cable was found at power-up, it drives an active-low reset pulse into the host. If there is no cable, it moves to a "host should reset" state that host software can poll, for example from a vertical-blank routine, and then reset itself.

In either case the controller waits for the host to signal that its reset has finished, rather than counting down a fixed delay, because machines differ in how long a reset takes. If no handshake arrives within a long watchdog interval, every LED blinks to ask the user to press the host's reset button. Once the handshake arrives, the controller receives the program bytes. A silent receive path times out back to idle, and a local button returns the controller to idle from any state.

Top module: `hrc_ctrl`

## Requirements
- R1: After reset, state_code is 0 (idle), host_rst_n is 1, all LEDs are 0 and go is 0.
- R2: With the cable latched, a run_req in idle drives host_rst_n low and state_code to 1 from the next cycle, for exactly PULSE_CYC cycles.
- R3: After the pulse, state_code becomes 2 (awaiting handshake). A host_done pulse there moves state_code to 5 (receiving) on the next cycle.
- R4: With no cable latched, a run_req in idle moves state_code to 3 (host should reset) and leaves host_rst_n at 1. A host_done pulse there moves state_code to 5.
- R5: cable_fitted is sampled only while rst is high. Changes to it after reset have no effect on which path is taken.
- R6: If no host_done arrives during HS_TIMEOUT cycles in state 2 or 3, state_code becomes 4 (manual reset) on the next cycle.
- R7: In state 4, all LEDs are lit for BLINK_DIV cycles and then dark for BLINK_DIV cycles, and this repeats. In every other state all LEDs are dark. A host_done pulse in state 4 moves state_code to 5.
- R8: In state 5, each rx_byte restarts the receive timer. After RX_TIMEOUT cycles with no byte, state_code returns to 0 and go stays 0.
- R9: rx_last in state 5 gives a single-cycle go pulse and state_code 0, both on the next cycle.
- R10: clear_btn returns state_code to 0 on the next cycle from any state, with host_rst_n at 1 and the LEDs dark.
- R11: A run_req while state_code is not 0 is ignored: the state and host_rst_n are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; cable_fitted is latched while it is high |
| clear_btn | input | 1 | Local button; returns the controller to idle |
| cable_fitted | input | 1 | High when a host reset cable is connected |
| run_req | input | 1 | Run request pulse from the USB command side |
| host_done | input | 1 | Handshake pulse from the host: its reset has finished |
| rx_byte | input | 1 | Strobe for one received program byte |
| rx_last | input | 1 | Strobe for the final byte of the transfer |
| host_rst_n | output | 1 | Active-low reset to the host |
| state_code | output | 3 | Host-readable state: 0 idle, 1 pulsing, 2 awaiting handshake, 3 host should reset, 4 manual, 5 receiving |
| leds | output | LED_N | Cartridge LEDs; all blink together in manual state |
| go | output | 1 | One-cycle pulse when a transfer completes |

## Verification
A wrong internal state shows up at once on state_code, which the host reads, and it also shows on host_rst_n and the LEDs within a cycle. Timer faults show up later. An off-by-one in the reset pulse, the handshake watchdog or the receive timeout moves the first cycle in which state_code changes by exactly one cycle, so the bench checks the cycle just before each expected edge and the cycle of the edge itself. A blink prescaler fault shows as a lit or dark LED phase of the wrong length.

// File: rtl/hrc_pkg.sv
package hrc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PULSE   = 3'd1,
        ST_AWAIT   = 3'd2,
        ST_SWRESET = 3'd3,
        ST_MANUAL  = 3'd4,
        ST_RECV    = 3'd5
    } hrc_state_e;

    function automatic logic awaits_host(hrc_state_e s);
        return (s == ST_AWAIT) || (s == ST_SWRESET);
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/hrc_timer.sv
module hrc_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         expired
);
    always_ff @(posedge clk) begin
        if (rst || restart)
            count <= '0;
        else if (count != {W{1'b1}})
            count <= count + 1'b1;
    end

    assign expired = (count == limit - 1'b1);

    // R8
    restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (count == '0));
endmodule

// File: rtl/hrc_blink.sv
module hrc_blink #(
    parameter int DIV   = 25_000_000,
    parameter int LED_N = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [LED_N-1:0] leds
);
    localparam int CW = $clog2(DIV + 1);

    logic [CW-1:0] pre;
    logic          phase;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pre   <= '0;
            phase <= 1'b1;
        end else if (pre == CW'(DIV - 1)) begin
            pre   <= '0;
            phase <= ~phase;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    assign leds = (en && phase) ? {LED_N{1'b1}} : '0;

    // R7
    dark_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> (leds == '0));
endmodule

// File: rtl/hrc_ctrl.sv
module hrc_ctrl
    import hrc_pkg::*;
#(
    parameter int PULSE_CYC  = 1000,
    parameter int HS_TIMEOUT = 200_000_000,
    parameter int RX_TIMEOUT = 10_000_000,
    parameter int BLINK_DIV  = 25_000_000,
    parameter int LED_N      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_btn,
    input  logic             cable_fitted,
    input  logic             run_req,
    input  logic             host_done,
    input  logic             rx_byte,
    input  logic             rx_last,
    output logic             host_rst_n,
    output logic [2:0]       state_code,
    output logic [LED_N-1:0] leds,
    output logic             go
);
    localparam int TW = $clog2(max3(PULSE_CYC, HS_TIMEOUT, RX_TIMEOUT) + 1);

    hrc_state_e    st, nxt;
    logic          cable_q;
    logic          restart, expired;
    logic [TW-1:0] limit, count;

    always_ff @(posedge clk) begin
        if (rst)
            cable_q <= cable_fitted;
    end

    always_comb begin
        case (st)
            ST_PULSE: limit = TW'(PULSE_CYC);
            ST_RECV:  limit = TW'(RX_TIMEOUT);
            default:  limit = TW'(HS_TIMEOUT);
        endcase
    end

    always_comb begin
        nxt = st;
        if (clear_btn) begin
            nxt = ST_IDLE;
        end else begin
            case (st)
                ST_IDLE:    if (run_req) nxt = cable_q ? ST_PULSE : ST_SWRESET;
                ST_PULSE:   if (expired) nxt = ST_AWAIT;
                ST_AWAIT,
                ST_SWRESET: if (host_done) nxt = ST_RECV;
                            else if (expired) nxt = ST_MANUAL;
                ST_MANUAL:  if (host_done) nxt = ST_RECV;
                ST_RECV:    if (rx_last) nxt = ST_IDLE;
                            else if (!rx_byte && expired) nxt = ST_IDLE;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    assign restart = (nxt != st) || (st == ST_RECV && rx_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
            go <= 1'b0;
        end else begin
            st <= nxt;
            go <= (st == ST_RECV) && rx_last && !clear_btn;
        end
    end

    hrc_timer #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .restart(restart), .limit(limit),
        .count(count), .expired(expired)
    );

    hrc_blink #(.DIV(BLINK_DIV), .LED_N(LED_N)) u_blink (
        .clk(clk), .rst(rst), .en(st == ST_MANUAL), .leds(leds)
    );

    assign host_rst_n = (st != ST_PULSE);
    assign state_code = st;

    // R2
    pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(host_rst_n) |-> ($past(run_req) && cable_q));
    // R2
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(host_rst_n) && !$past(clear_btn) |-> ($past(count) == TW'(PULSE_CYC - 1)));
    // R10
    clear_idle_chk: assert property (@(posedge clk) disable iff (rst)
        clear_btn |=> (st == ST_IDLE && host_rst_n));
    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RECV && !rx_last && !rx_byte && !expired && !clear_btn) |=> (st == ST_RECV));
    // R9
    go_source_chk: assert property (@(posedge clk) disable iff (rst)
        go |-> ($past(st) == ST_RECV && st == ST_IDLE));
    // R7
    leds_manual_chk: assert property (@(posedge clk) disable iff (rst)
        (leds != '0) |-> (st == ST_MANUAL));
    // R4
    sw_path_chk: assert property (@(posedge clk) disable iff (rst)
        awaits_host(st) |-> host_rst_n);
endmodule

// File: tb/hrc_ctrl_test.sv
module hrc_ctrl_test;
    localparam int PC = 4, HS = 50, RX = 20, BD = 5, LN = 4;

    logic clk = 0, rst = 1, clear_btn = 0, cable_fitted = 0, run_req = 0;
    logic host_done = 0, rx_byte = 0, rx_last = 0;
    logic host_rst_n, go;
    logic [2:0] state_code;
    logic [LN-1:0] leds;
    int total = 0, fails = 0;

    always #5 clk = ~clk;

    hrc_ctrl #(.PULSE_CYC(PC), .HS_TIMEOUT(HS), .RX_TIMEOUT(RX),
               .BLINK_DIV(BD), .LED_N(LN)) uut (
        .clk(clk), .rst(rst), .clear_btn(clear_btn), .cable_fitted(cable_fitted),
        .run_req(run_req), .host_done(host_done), .rx_byte(rx_byte), .rx_last(rx_last),
        .host_rst_n(host_rst_n), .state_code(state_code), .leds(leds), .go(go));

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(logic cab);
        rst = 1; cable_fitted = cab; tick(2); rst = 0; tick();
    endtask

    task automatic pulse_run();
        run_req = 1; tick(); run_req = 0;
    endtask

    task automatic pulse_done();
        host_done = 1; tick(); host_done = 0;
    endtask

    task automatic t_reset();
        do_reset(1);
        chk("R1 state", state_code, 0);
        chk("R1 rst_n", host_rst_n, 1);
        chk("R1 leds", leds, 0);
        chk("R1 go", go, 0);
    endtask

    task automatic t_cable_path();
        int low = 0;
        do_reset(1);
        pulse_run();
        chk("R2 code", state_code, 1);
        while (!host_rst_n && low < 100) begin low++; tick(); end
        chk("R2 pulse len", low, PC);
        chk("R3 await", state_code, 2);
        pulse_done();
        chk("R3 recv", state_code, 5);
        rx_byte = 1; tick(); rx_byte = 0;
        rx_last = 1; tick(); rx_last = 0;
        chk("R9 go", go, 1);
        chk("R9 idle", state_code, 0);
        tick();
        chk("R9 go single", go, 0);
    endtask

    task automatic t_soft_path();
        do_reset(0);
        cable_fitted = 1;
        pulse_run();
        chk("R4 code", state_code, 3);
        chk("R4 rst_n", host_rst_n, 1);
        chk("R5 latched", state_code, 3);
        pulse_done();
        chk("R4 recv", state_code, 5);
    endtask

    task automatic t_watchdog_blink();
        do_reset(0);
        pulse_run();
        tick(HS - 1);
        chk("R6 before", state_code, 3);
        tick();
        chk("R6 manual", state_code, 4);
        chk("R7 lit", leds, 4'hF);
        tick(BD - 1);
        chk("R7 lit end", leds, 4'hF);
        tick();
        chk("R7 dark", leds, 0);
        tick(BD);
        chk("R7 relit", leds, 4'hF);
        pulse_done();
        chk("R7 recv", state_code, 5);
        chk("R7 leds off", leds, 0);
    endtask

    task automatic t_rx_timeout();
        do_reset(1);
        pulse_run(); tick(PC); pulse_done();
        chk("R8 recv", state_code, 5);
        tick(10);
        rx_byte = 1; tick(); rx_byte = 0;
        tick(RX - 1);
        chk("R8 restarted", state_code, 5);
        tick();
        chk("R8 timeout", state_code, 0);
        chk("R8 no go", go, 0);
    endtask

    task automatic t_busy_ignore();
        do_reset(1);
        pulse_run(); tick(PC); pulse_done();
        pulse_run();
        chk("R11 stay recv", state_code, 5);
        chk("R11 rst_n", host_rst_n, 1);
        clear_btn = 1; tick(); clear_btn = 0;
        pulse_run();
        chk("R11 after idle", state_code, 1);
        clear_btn = 1; tick(); clear_btn = 0;
        chk("R10 idle", state_code, 0);
        chk("R10 rst_n", host_rst_n, 1);
        do_reset(0);
        pulse_run(); tick(HS);
        clear_btn = 1; tick(); clear_btn = 0;
        chk("R10 from manual", state_code, 0);
        chk("R10 leds", leds, 0);
    endtask

    initial begin
        t_reset();
        t_cable_path();
        t_soft_path();
        t_watchdog_blink();
        t_rx_timeout();
        t_busy_ignore();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #100000;
        total++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule